// File: doc/BRIEF.md
# Serial Bit-Access Protected Memory Controller

This block sits in front of a 192-cell non-volatile array (24 rows of 8 cells) and serves it through three serial lines: a reset line, a card clock line and a data line. It reaches one cell at a time. A single address register starts at zero and only counts upward, so the host reaches a cell by sending the reset command and then clocking the address forward. All line edges are sampled on the system clock.

A complete clock pulse with the reset line low advances the address. The addressed bit is always driven on `data_out`. A rising data line during the high phase of the clock requests a program operation. The request writes a 0 cell to 1, or it clears the whole byte (row) when the addressed cell already holds 1. Rights depend on the address region and on the mode input, which models the fuse that separates manufacturer initialisation from end use. A request to a protected cell is dropped and raises a violation flag. An accepted request keeps the block busy for a fixed number of cycles, and the cell changes when that time ends.

The counter region is 48 cells, laid out as six bytes of eight cells each. Host software runs it as a six-digit octal abacus, which gives 262,144 units, and it uses the byte clear to handle carries.

Top module: `serial_bitmem`

## Requirements
- R1: After synchronous reset the address is 0, every cell is 0, and `busy`, `violation` and `data_out` are 0.
- R2: A rising card clock while the reset line is high (HOME) sets the address to 0 and clears `violation`.
- R3: A card clock pulse with the reset line low advances the address by one when the clock falls. The pulse must not have carried HOME or a data pulse. After the fall, `data_out` shows the new cell. The address runs 0 to 263 and wraps from 263 to 0.
- R4: A data-line rise while the card clock has been high for at least one system cycle and the reset line is low (PROG) acts on a 0 cell that may be written: that cell becomes 1 when the busy time ends, and the address does not move.
- R5: PROG on a cell that already holds 1, in a region that may be erased, clears all 8 cells of its byte (addresses 8k to 8k+7) when the busy time ends.
- R6: An accepted PROG holds `busy` high for exactly PROG_CYCLES system cycles, starting the cycle after the data edge. Every command that arrives while `busy` is high is ignored.
- R7: In user mode (`user_mode`=1) only addresses 64 to 111 may be written or erased.
- R8: In issuer mode (`user_mode`=0), writes are allowed at addresses 16 to 191 and erases at 64 to 191. Addresses 0 to 15 are never writable.
- R9: A PROG that is not allowed leaves every cell unchanged and does not start `busy`. It sets `violation`, which stays high until the next HOME.
- R10: Addresses 192 to 263 hold no cells and are never writable. There `data_out` reads 0, except at address 260, where it reads `user_mode`.
- R11: A data-line pulse while the card clock is low has no effect on the address, the cells, `busy` or `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| user_mode | input | 1 | Mode fuse: 0 issuer, 1 user |
| line_rst | input | 1 | Serial reset line |
| line_clk | input | 1 | Serial card clock line |
| line_io | input | 1 | Serial data line (program strobe input) |
| data_out | output | 1 | Bit at the current address |
| busy | output | 1 | Program or erase in progress |
| violation | output | 1 | Sticky flag for a refused program request |

## Verification
A wrong address register shows up on `data_out` as soon as the first clock fall has been decoded. A pattern of set cells therefore turns an off-by-one or a missed wrap into a bit mismatch within a few cycles. A wrong busy counter or a misplaced commit shows as a `busy` edge one cycle early or late. It can also show as a cell that reads back the wrong value on the cycle `busy` drops. A rights error moves `violation` and `busy` in the cycle after the data edge. The bench steps a behavioural model every clock and compares all three outputs on every cycle, so each such fault is reported in the cycle it first appears.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int ROWS        = 24;
    localparam int COLS        = 8;
    localparam int CELLS       = ROWS * COLS;
    localparam int ADDR_W      = 9;
    localparam int COL_W       = $clog2(COLS);
    localparam int ROW_W       = ADDR_W - COL_W;
    localparam int IDX_W       = $clog2(CELLS);
    localparam int ADDR_LAST   = 263;
    localparam int FUSE_ADDR   = 260;

    localparam int CARD_BASE   = 16;
    localparam int COUNT_BASE  = 64;
    localparam int CERT_BASE   = 112;
    localparam int ISSUER_BASE = 128;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_HOME,
        CMD_STEP,
        CMD_PROG
    } cmd_e;

    typedef enum logic [2:0] {
        RG_CIRCUIT,
        RG_CARD,
        RG_COUNT,
        RG_CERT,
        RG_ISSUER,
        RG_VOID
    } region_e;

    typedef struct packed {
        logic may_set;
        logic may_clear;
    } rights_t;

    typedef struct packed {
        addr_t addr;
        logic  clear;
    } job_t;

    function automatic region_e region_of(addr_t a);
        int v;
        v = int'(a);
        if (v < CARD_BASE)        return RG_CIRCUIT;
        else if (v < COUNT_BASE)  return RG_CARD;
        else if (v < CERT_BASE)   return RG_COUNT;
        else if (v < ISSUER_BASE) return RG_CERT;
        else if (v < CELLS)       return RG_ISSUER;
        else                      return RG_VOID;
    endfunction

    function automatic rights_t rights_of(region_e r, logic user);
        rights_t g;
        g = '0;
        case (r)
            RG_CARD:   g.may_set = !user;
            RG_COUNT:  begin g.may_set = 1'b1;  g.may_clear = 1'b1;  end
            RG_CERT,
            RG_ISSUER: begin g.may_set = !user; g.may_clear = !user; end
            default:   g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
    import sbm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_rst,
    input  logic line_clk,
    input  logic line_io,
    output cmd_e cmd
);

    logic clk_q;
    logic io_q;
    logic used_q;
    logic rise;
    logic fall;
    logic strobe;

    assign rise   = line_clk && !clk_q;
    assign fall   = !line_clk && clk_q;
    assign strobe = line_clk && clk_q && line_io && !io_q && !line_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= 1'b0;
            io_q   <= 1'b0;
            used_q <= 1'b0;
        end else begin
            clk_q <= line_clk;
            io_q  <= line_io;
            if (rise)        used_q <= line_rst;
            else if (strobe) used_q <= 1'b1;
        end
    end

    always_comb begin
        cmd = CMD_NONE;
        if (rise && line_rst)                   cmd = CMD_HOME;
        else if (fall && !used_q && !line_rst)  cmd = CMD_STEP;
        else if (strobe)                        cmd = CMD_PROG;
    end

endmodule

// File: rtl/sbm_prog_timer.sv
module sbm_prog_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)            left <= '0;
        else if (start)     left <= CW'(CYCLES);
        else if (left != 0) left <= left - 1'b1;
    end

    assign busy = (left != 0);
    assign done = (left == CW'(1));

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/sbm_cell_array.sv
module sbm_cell_array
    import sbm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  job_t  job,
    input  addr_t rd_addr,
    output logic  rd_bit
);

    logic [CELLS-1:0] flat;
    logic [ROW_W-1:0] job_row;
    logic [COL_W-1:0] job_col;

    assign job_row = job.addr[ADDR_W-1:COL_W];
    assign job_col = job.addr[COL_W-1:0];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] cells;
        logic            hit;
        assign hit = commit && (job_row == ROW_W'(r));
        always_ff @(posedge clk) begin
            if (rst)                   cells <= '0;
            else if (hit && job.clear) cells <= '0;
            else if (hit)              cells[job_col] <= 1'b1;
        end
        assign flat[r*COLS +: COLS] = cells;
    end

    assign rd_bit = (int'(rd_addr) < CELLS) ? flat[rd_addr[IDX_W-1:0]] : 1'b0;

    // R4
    set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && !job.clear) |=> flat[$past(job.addr[IDX_W-1:0])]);

    // R5
    clear_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && job.clear) |=> !flat[$past(job.addr[IDX_W-1:0])]);

endmodule

// File: rtl/serial_bitmem.sv
module serial_bitmem
    import sbm_pkg::*;
#(
    parameter int PROG_CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic user_mode,
    input  logic line_rst,
    input  logic line_clk,
    input  logic line_io,
    output logic data_out,
    output logic busy,
    output logic violation
);

    cmd_e    cmd;
    addr_t   addr_q;
    logic    viol_q;
    job_t    job_q;
    region_e reg_now;
    rights_t grant;
    logic    rd_bit;
    logic    start;
    logic    deny;
    logic    done;

    sbm_cmd_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .line_rst (line_rst),
        .line_clk (line_clk),
        .line_io  (line_io),
        .cmd      (cmd)
    );

    sbm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    sbm_cell_array u_cells (
        .clk     (clk),
        .rst     (rst),
        .commit  (done),
        .job     (job_q),
        .rd_addr (addr_q),
        .rd_bit  (rd_bit)
    );

    assign reg_now = region_of(addr_q);
    assign grant   = rights_of(reg_now, user_mode);

    always_comb begin
        start = 1'b0;
        deny  = 1'b0;
        if (!busy && cmd == CMD_PROG) begin
            if (rd_bit ? grant.may_clear : grant.may_set) start = 1'b1;
            else                                          deny  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            viol_q <= 1'b0;
            job_q  <= '0;
        end else begin
            if (!busy) begin
                case (cmd)
                    CMD_HOME: begin
                        addr_q <= '0;
                        viol_q <= 1'b0;
                    end
                    CMD_STEP: addr_q <= (addr_q == addr_t'(ADDR_LAST)) ? '0 : addr_q + 1'b1;
                    default:  ;
                endcase
            end
            if (deny)  viol_q <= 1'b1;
            if (start) job_q  <= '{addr: addr_q, clear: rd_bit};
        end
    end

    assign data_out  = (addr_q == addr_t'(FUSE_ADDR)) ? user_mode : rd_bit;
    assign violation = viol_q;

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == CMD_STEP && addr_q == addr_t'(ADDR_LAST)) |=> (addr_q == '0));

    // R2
    home_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd == CMD_HOME) |=> (!violation && addr_q == '0));

    // R9
    deny_flag_chk: assert property (@(posedge clk) disable iff (rst)
        deny |=> (violation && !busy));

    // R7
    user_rights_chk: assert property (@(posedge clk) disable iff (rst)
        (start && user_mode) |-> (reg_now == RG_COUNT));

    // R8
    issuer_rights_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !user_mode) |-> (reg_now != RG_CIRCUIT && reg_now != RG_VOID));

endmodule

// File: tb/serial_bitmem_test.sv
module serial_bitmem_test;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic user_mode = 1'b0;
    logic line_rst = 1'b0;
    logic line_clk = 1'b0;
    logic line_io = 1'b0;
    logic data_out, busy, violation;

    int checks = 0;
    int errors = 0;
    bit live = 1'b0;
    bit ended = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_bitmem #(.PROG_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .user_mode(user_mode),
        .line_rst(line_rst), .line_clk(line_clk), .line_io(line_io),
        .data_out(data_out), .busy(busy), .violation(violation)
    );

    // behavioural reference
    bit m_mem [192];
    int m_addr, m_cnt, m_pend_addr;
    bit m_pend_clear, m_viol, m_clk_q, m_io_q, m_used;

    function automatic bit m_read(int a);
        if (a < 192) return m_mem[a];
        if (a == 260) return user_mode;
        return 1'b0;
    endfunction

    function automatic bit m_allowed(int a, bit clr, bit usr);
        if (a >= 192) return 1'b0;
        if (usr) return (a >= 64 && a < 112);
        if (clr) return (a >= 64);
        return (a >= 16);
    endfunction

    always @(posedge clk) begin
        bit rise, fall, pe, cur;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 1'b0;
            m_addr = 0; m_cnt = 0; m_viol = 0;
            m_clk_q = 0; m_io_q = 0; m_used = 0;
        end else begin
            rise = line_clk && !m_clk_q;
            fall = !line_clk && m_clk_q;
            pe   = line_clk && m_clk_q && line_io && !m_io_q && !line_rst;
            if (m_cnt > 0) begin
                if (m_cnt == 1) begin
                    if (m_pend_clear)
                        for (int i = 0; i < 8; i++) m_mem[(m_pend_addr/8)*8 + i] = 1'b0;
                    else
                        m_mem[m_pend_addr] = 1'b1;
                end
                m_cnt--;
            end else if (rise && line_rst) begin
                m_addr = 0; m_viol = 0;
            end else if (fall && !m_used && !line_rst) begin
                m_addr = (m_addr == 263) ? 0 : m_addr + 1;
            end else if (pe) begin
                cur = (m_addr < 192) ? m_mem[m_addr] : 1'b0;
                if (m_allowed(m_addr, cur, user_mode)) begin
                    m_pend_addr = m_addr; m_pend_clear = cur; m_cnt = P;
                end else m_viol = 1'b1;
            end
            if (rise) m_used = line_rst;
            else if (pe) m_used = 1'b1;
            m_clk_q = line_clk; m_io_q = line_io;
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    int busy_run = 0;
    int last_busy_len = 0;
    always @(negedge clk) begin
        if (live && !ended) begin
            check(cur_req, data_out, m_read(m_addr), "data_out vs model");
            check(cur_req, busy, (m_cnt > 0), "busy vs model");
            check(cur_req, violation, m_viol, "violation vs model");
            if (busy) busy_run++;
            else begin
                if (busy_run != 0) last_busy_len = busy_run;
                busy_run = 0;
            end
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    task automatic wait_cyc(int n); repeat (n) @(negedge clk); endtask
    task automatic card_pulse(logic r);
        line_rst = r; wait_cyc(1);
        line_clk = 1'b1; wait_cyc(2);
        line_clk = 1'b0; line_rst = 1'b0; wait_cyc(1);
    endtask
    task automatic home(); card_pulse(1'b1); endtask
    task automatic step(int n); for (int i = 0; i < n; i++) card_pulse(1'b0); endtask
    task automatic go_to(int a); home(); step(a); endtask
    task automatic prog_pulse();
        line_clk = 1'b1; wait_cyc(1);
        line_io = 1'b1;  wait_cyc(1);
        line_io = 1'b0;  wait_cyc(1);
        line_clk = 1'b0; wait_cyc(1);
    endtask
    task automatic settle(); while (busy) @(negedge clk); wait_cyc(1); endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        live = 1'b1;
        wait_cyc(1);
        cur_req = "R1";
        check("R1", data_out, 1'b0, "data_out after reset");
        check("R1", busy, 1'b0, "busy after reset");
        check("R1", violation, 1'b0, "violation after reset");

        cur_req = "R4";
        go_to(20); prog_pulse(); settle();
        check("R4", data_out, 1'b1, "bit 20 set, address unchanged");
        check("R6", last_busy_len[0] === 1'b0 && last_busy_len == P, 1'b1, "busy length equals PROG_CYCLES");

        cur_req = "R6";
        go_to(30); prog_pulse(); step(1); settle();
        check("R6", data_out, 1'b1, "step during busy ignored");
        step(1);
        check("R3", data_out, 1'b0, "step to 31");

        cur_req = "R9";
        go_to(5); prog_pulse(); wait_cyc(2);
        check("R9", violation, 1'b1, "circuit id write refused");
        check("R9", busy, 1'b0, "refused request not busy");
        check("R8", data_out, 1'b0, "cell 5 unchanged");
        cur_req = "R2";
        home();
        check("R2", violation, 1'b0, "home clears violation");

        cur_req = "R5";
        go_to(66); prog_pulse(); settle();
        go_to(70); prog_pulse(); settle();
        check("R5", data_out, 1'b1, "bit 70 set");
        prog_pulse(); settle();
        check("R5", data_out, 1'b0, "bit 70 erased");
        go_to(66);
        check("R5", data_out, 1'b0, "bit 66 erased with byte");

        cur_req = "R8";
        go_to(120); prog_pulse(); settle();
        check("R8", data_out, 1'b1, "issuer writes certificate");

        cur_req = "R7";
        user_mode = 1'b1;
        go_to(120); prog_pulse(); wait_cyc(2);
        check("R7", violation, 1'b1, "user erase of certificate refused");
        check("R7", data_out, 1'b1, "certificate cell kept");
        go_to(80); prog_pulse(); settle();
        check("R7", data_out, 1'b1, "user writes counter");
        go_to(40); prog_pulse(); wait_cyc(2);
        check("R7", violation, 1'b1, "user write of card id refused");

        cur_req = "R10";
        go_to(200); prog_pulse(); wait_cyc(2);
        check("R10", violation, 1'b1, "unused address refused");
        check("R10", data_out, 1'b0, "unused reads 0");
        go_to(260);
        check("R10", data_out, 1'b1, "fuse reads user mode");
        user_mode = 1'b0; wait_cyc(1);
        check("R10", data_out, 1'b0, "fuse follows mode");

        cur_req = "R3";
        step(3);
        check("R3", data_out, 1'b0, "address 263");
        step(1); step(20);
        check("R3", data_out, 1'b1, "wrapped to 0 then reached 20");

        cur_req = "R11";
        go_to(40);
        line_io = 1'b1; wait_cyc(2); line_io = 1'b0; wait_cyc(2);
        check("R11", busy, 1'b0, "io pulse with clock low not busy");
        check("R11", violation, 1'b0, "io pulse with clock low no flag");
        step(1);
        check("R11", data_out, 1'b0, "address still advanced from 40");

        wait_cyc(2);
        finish_run();
    end

endmodule